// File: doc/BRIEF.md
# Buffered I2C Command Engine

This block is an I2C bus master that runs a complete transaction from a small byte buffer. Software writes the target address byte and any outgoing data into the buffer, then issues one control write. That write carries a start flag and the total number of bytes in the frame, address byte included. The engine then produces the whole frame on open-drain SCL and SDA: a START, the address byte, the data bytes, and a STOP. Software polls a two-bit status code to learn whether the transfer is running, finished cleanly, or was refused by the target.

Bit 0 of buffer byte 0 selects the direction. When it is 0, every following buffer byte is sent. When it is 1, the engine clocks in the remaining bytes from the target and writes them back into the buffer, starting at byte 1. The master acknowledges each received byte except the last, which it leaves unacknowledged so the target releases the bus. The SCL rate comes from a quarter-period parameter, so one SCL period takes four such quarters.

Top module: `i2cbuf_engine`

## Requirements
- R1: Register offsets are 0 for control, 1 for status and 2 to DEPTH+1 for buffer bytes 0 to DEPTH-1. Status carries its code in bits 7:6, and its other bits read 0. The control offset and any offset above the buffer read 0. After reset the status and every buffer byte read 0.
- R2: A control write while idle, with bit 7 set and bits 6:0 holding a count N from 1 to DEPTH, starts an N-byte transfer. From the next cycle the status code reads 10 (busy).
- R3: A start write with a count of 0, or with a count greater than DEPTH, is ignored. The status stays as it was and no START appears on the bus.
- R4: When byte 0 bit 0 is 0, buffer bytes 0 to N-1 go out MSB first. Each byte is followed by an acknowledge slot in which the master releases SDA. The frame then ends with a STOP, and the status code becomes 01.
- R5: When byte 0 bit 0 is 1, the N-1 bytes after the address are received MSB first and stored into buffer bytes 1 to N-1. The master drives ACK after each of these bytes except the last, and leaves the last one unacknowledged.
- R6: If any byte the master sends is not acknowledged, the engine sends no further bytes, issues a STOP, and sets the status code to 11.
- R7: SDA changes only while SCL is held low. There are two exceptions, each appearing exactly once per transfer: the START, where SDA falls while SCL is high, and the STOP, where SDA rises while SCL is high.
- R8: During a transfer, each SCL low phase lasts 2*QTR_CYCLES clocks, and so does each high phase that lies between two falling edges.
- R9: While a transfer is running, writes to the control register and to buffer bytes have no effect.
- R10: Writing 0 to the control register while idle returns the status code to 00.
- R11: Whenever no transfer is running, neither SCL nor SDA is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | AW (6 by default) | Register byte offset |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational from regAddr) |
| sclDriveLow | output | 1 | Pull SCL low when 1, release when 0 |
| sdaDriveLow | output | 1 | Pull SDA low when 1, release when 0 |
| sdaIn | input | 1 | Sensed level of the SDA line |

## Verification
Two situations are hard to reach from the register port alone: the master's handling of a refused acknowledge, and its own ACK/NACK pattern on received data. Both depend on what a target does in the ninth clock of each byte. The bench therefore contains a bus-level target model. It watches SCL edges, decodes START and STOP, and drives SDA only while SCL is low. Per run it can refuse any chosen byte, including the address byte, and it serves a computed pattern on reads. Writes that arrive in the middle of a running transfer are issued while the busy code is showing, and their lack of effect is proven afterwards from the bytes the target received and from the buffer readback.

// File: rtl/i2cbuf_pkg.sv
package i2cbuf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_DONE = 2'b01,
    ST_BUSY = 2'b10,
    ST_ERR  = 2'b11
  } statusCode_t;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_START,
    FS_XFER,
    FS_STOP
  } fsmState_t;

  // strobes from the sequencer to the byte datapath
  typedef struct packed {
    logic launch;   // latch count and direction, load byte 0
    logic shift;    // shift one sampled bit into the byte register
    logic store;    // write the received byte back into the buffer
    logic advance;  // move to the next buffer byte
  } dpStrobe_t;

endpackage

// File: rtl/i2cbuf_datapath.sv
module i2cbuf_datapath
  import i2cbuf_pkg::*;
#(
  parameter int DEPTH = 50,
  parameter int AW    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [AW-1:0]     regAddr,
  input  logic              regWe,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  logic              busy,
  input  statusCode_t       status,
  input  dpStrobe_t         strb,
  input  logic              sdaSample,
  output logic              ctrlWr,
  output logic              txBit,
  output logic              txByte,
  output logic              lastByte
);

  localparam int BASE = 2;
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]    mem [DEPTH];
  logic [7:0]    shiftReg;
  logic [IW-1:0] byteIdx;
  logic [6:0]    xferCount;
  logic          readMode;

  logic          dataSel;
  logic [AW-1:0] offs;
  logic [IW-1:0] dataIdx;
  logic [IW-1:0] nextIdx;

  assign offs    = regAddr - AW'(BASE);
  assign dataIdx = offs[IW-1:0];
  assign dataSel = (regAddr >= AW'(BASE)) && (regAddr < AW'(BASE + DEPTH));
  assign ctrlWr  = regWe && (regAddr == '0);
  assign nextIdx = byteIdx + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (regWe && dataSel && !busy) begin
      mem[dataIdx] <= regWdata;
    end else if (strb.store) begin
      mem[byteIdx] <= shiftReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= 8'h00;
      byteIdx   <= '0;
      xferCount <= 7'd0;
      readMode  <= 1'b0;
    end else if (strb.launch) begin
      shiftReg  <= mem[0];
      byteIdx   <= '0;
      xferCount <= regWdata[6:0];
      readMode  <= mem[0][0];
    end else if (strb.advance) begin
      shiftReg  <= mem[nextIdx];
      byteIdx   <= nextIdx;
    end else if (strb.shift) begin
      shiftReg  <= {shiftReg[6:0], sdaSample};
    end
  end

  assign txBit    = shiftReg[7];
  assign txByte   = (byteIdx == '0) || !readMode;
  assign lastByte = (7'(byteIdx) == xferCount - 7'd1);

  always_comb begin
    regRdata = 8'h00;
    if (regAddr == AW'(1)) regRdata = {status, 6'b000000};
    else if (dataSel)      regRdata = mem[dataIdx];
  end

endmodule

// File: rtl/i2cbuf_ctrl.sv
module i2cbuf_ctrl
  import i2cbuf_pkg::*;
#(
  parameter int DEPTH      = 50,
  parameter int QTR_CYCLES = 312
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlWr,
  input  logic [7:0]  ctrlData,
  input  logic        sdaSample,
  input  logic        txBit,
  input  logic        txByte,
  input  logic        lastByte,
  output logic        busy,
  output statusCode_t status,
  output dpStrobe_t   strb,
  output logic        sclDriveLow,
  output logic        sdaDriveLow
);

  localparam int TW = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
  localparam logic [TW-1:0] RELOAD = TW'(QTR_CYCLES - 1);

  fsmState_t   state;
  statusCode_t statusQ;
  logic [1:0]  phase;
  logic [3:0]  bitCnt;
  logic [TW-1:0] timer;
  logic        sclDrv, sdaDrv, errFlag;

  logic tick, startOk, zeroWr, sampleEdge, ackSlot, nackSeen, bitLow;

  assign tick       = (timer == '0);
  assign startOk    = ctrlWr && ctrlData[7] && (ctrlData[6:0] != 7'd0)
                      && (int'(ctrlData[6:0]) <= DEPTH);
  assign zeroWr     = ctrlWr && (ctrlData == 8'h00);
  assign sampleEdge = (state == FS_XFER) && tick && (phase == 2'd3);
  assign ackSlot    = sampleEdge && (bitCnt == 4'd8);
  assign nackSeen   = ackSlot && txByte && sdaSample;

  always_comb begin
    strb.launch  = (state == FS_IDLE) && startOk;
    strb.shift   = sampleEdge && (bitCnt < 4'd8);
    strb.store   = ackSlot && !txByte;
    strb.advance = ackSlot && !nackSeen && !lastByte;
  end

  // level to put on SDA for the current bit: 1 pulls low
  always_comb begin
    if (bitCnt < 4'd8) bitLow = txByte ? !txBit : 1'b0;
    else               bitLow = txByte ? 1'b0 : !lastByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= FS_IDLE;
      statusQ <= ST_IDLE;
      phase   <= 2'd0;
      bitCnt  <= 4'd0;
      timer   <= '0;
      sclDrv  <= 1'b0;
      sdaDrv  <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      if (state != FS_IDLE) begin
        if (tick) begin
          timer <= RELOAD;
          phase <= phase + 2'd1;
        end else begin
          timer <= timer - 1'b1;
        end
      end
      case (state)
        FS_IDLE: begin
          if (startOk) begin
            state   <= FS_START;
            statusQ <= ST_BUSY;
            phase   <= 2'd0;
            timer   <= RELOAD;
            bitCnt  <= 4'd0;
            errFlag <= 1'b0;
          end else if (zeroWr) begin
            statusQ <= ST_IDLE;
          end
        end
        FS_START: begin
          if (tick && phase == 2'd1) sdaDrv <= 1'b1;
          if (tick && phase == 2'd3) begin
            state  <= FS_XFER;
            sclDrv <= 1'b1;
            bitCnt <= 4'd0;
          end
        end
        FS_XFER: begin
          if (tick) begin
            case (phase)
              2'd0: sdaDrv <= bitLow;
              2'd1: sclDrv <= 1'b0;
              2'd3: begin
                sclDrv <= 1'b1;
                if (bitCnt < 4'd8) begin
                  bitCnt <= bitCnt + 4'd1;
                end else if (nackSeen) begin
                  errFlag <= 1'b1;
                  state   <= FS_STOP;
                end else if (lastByte) begin
                  state   <= FS_STOP;
                end else begin
                  bitCnt  <= 4'd0;
                end
              end
              default: ;
            endcase
          end
        end
        FS_STOP: begin
          if (tick) begin
            case (phase)
              2'd0: sdaDrv <= 1'b1;
              2'd1: sclDrv <= 1'b0;
              2'd3: begin
                sdaDrv  <= 1'b0;
                state   <= FS_IDLE;
                statusQ <= errFlag ? ST_ERR : ST_DONE;
              end
              default: ;
            endcase
          end
        end
        default: state <= FS_IDLE;
      endcase
    end
  end

  assign busy        = (state != FS_IDLE);
  assign status      = statusQ;
  assign sclDriveLow = sclDrv;
  assign sdaDriveLow = sdaDrv;

endmodule

// File: rtl/i2cbuf_engine.sv
module i2cbuf_engine
  import i2cbuf_pkg::*;
#(
  parameter int DEPTH      = 50,
  parameter int QTR_CYCLES = 312,
  localparam int AW        = $clog2(DEPTH + 3)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] regAddr,
  input  logic          regWe,
  input  logic [7:0]    regWdata,
  output logic [7:0]    regRdata,
  output logic          sclDriveLow,
  output logic          sdaDriveLow,
  input  logic          sdaIn
);

  logic        busy, ctrlWr, txBit, txByte, lastByte;
  statusCode_t status;
  dpStrobe_t   strb;

  i2cbuf_datapath #(.DEPTH(DEPTH), .AW(AW)) u_dp (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .busy(busy), .status(status), .strb(strb), .sdaSample(sdaIn),
    .ctrlWr(ctrlWr), .txBit(txBit), .txByte(txByte), .lastByte(lastByte)
  );

  i2cbuf_ctrl #(.DEPTH(DEPTH), .QTR_CYCLES(QTR_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .ctrlWr(ctrlWr), .ctrlData(regWdata), .sdaSample(sdaIn),
    .txBit(txBit), .txByte(txByte), .lastByte(lastByte),
    .busy(busy), .status(status), .strb(strb),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow)
  );

endmodule

// File: rtl/i2cbuf_checker.sv
module i2cbuf_checker #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rstN,
  input logic          busy,
  input logic          sclDriveLow,
  input logic          sdaDriveLow,
  input logic          regWe,
  input logic [AW-1:0] regAddr,
  input logic [7:0]    regWdata,
  input logic          strbStore,
  input logic          txByte
);

  assert_bus_released_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclDriveLow && !sdaDriveLow));

  assert_start_from_ctrl_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(regWe && (regAddr == '0) && regWdata[7]));

  assert_start_edge_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaDriveLow) && !sclDriveLow && $past(!sclDriveLow)) |-> busy);

  assert_stop_edge_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sdaDriveLow) && !sclDriveLow && $past(!sclDriveLow)) |-> !busy);

  assert_store_rx_only_R5: assert property (@(posedge clk) disable iff (!rstN)
    strbStore |-> !txByte);

endmodule

bind i2cbuf_engine i2cbuf_checker #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy),
  .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
  .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
  .strbStore(strb.store), .txByte(txByte)
);

// File: tb/i2cbuf_engine_tb.sv
`timescale 1ns/1ps
module i2cbuf_engine_tb;

  localparam int DEPTH = 50;
  localparam int Q     = 4;
  localparam int AW    = $clog2(DEPTH + 3);

  // {count, address byte, target refuses byte (FF none), expected status}
  localparam logic [31:0] VEC [7] = '{
    32'h03_A0_FF_01, 32'h04_A1_FF_01, 32'h01_84_FF_01, 32'h05_3C_02_03,
    32'h02_A3_00_03, 32'h32_22_FF_01, 32'h32_23_FF_01
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic regWe = 1'b0;
  logic [7:0] regWdata = 8'h00, regRdata;
  logic sclDriveLow, sdaDriveLow, sdaIn;
  logic tgtSdaLow = 1'b0;

  always #4 clk = ~clk;

  assign sdaIn = !(sdaDriveLow || tgtSdaLow);

  i2cbuf_engine #(.DEPTH(DEPTH), .QTR_CYCLES(Q)) u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow), .sdaIn(sdaIn)
  );

  function automatic logic [7:0] rdPat(int i);
    return 8'((i * 29) ^ 195);
  endfunction
  function automatic logic [7:0] payload(int v, int i);
    return 8'(i * 13 + v * 7 + 90);
  endfunction

  // ---------------- target model ----------------
  int nackAt = -1;
  int starts = 0, stops = 0, tByte = 0, tBit = 0, lowLen = 0, highLen = 0;
  int timingBad = 0, timingSeen = 0;
  logic inFrame = 0, tRead = 0, tDone = 0, sawRise = 0;
  logic prevScl = 1, prevSda = 1;
  logic [7:0] tShift = 0;
  logic [7:0] rxBytes [64];
  logic ackSeen [64];

  always @(negedge clk) begin
    logic sclNow, sdaNow;
    logic [7:0] pat;
    sclNow = !sclDriveLow;
    sdaNow = sdaIn;
    if (prevScl && sclNow && prevSda && !sdaNow) begin
      starts++; inFrame = 1; tByte = 0; tBit = 0; tShift = 0;
      tRead = 0; tDone = 0; sawRise = 0; tgtSdaLow = 0;
    end else if (prevScl && sclNow && !prevSda && sdaNow) begin
      stops++; inFrame = 0; tgtSdaLow = 0;
    end else if (inFrame && !prevScl && sclNow) begin
      timingSeen++;
      if (lowLen != 2 * Q) timingBad++;
      if (tBit < 8) begin
        tShift = {tShift[6:0], sdaNow}; tBit++;
      end else begin
        if (tByte < 64) begin rxBytes[tByte] = tShift; ackSeen[tByte] = !sdaNow; end
        if (tByte == 0) tRead = tShift[0];
        if (tByte == nackAt) tDone = 1;
        if (tByte >= 1 && tRead && sdaNow) tDone = 1;
        tByte++; tBit = 0;
      end
      highLen = 0; sawRise = 1;
    end else if (inFrame && prevScl && !sclNow) begin
      if (sawRise && highLen != 2 * Q) timingBad++;
      lowLen = 0;
      if (tBit == 8) begin
        tgtSdaLow = ((tByte == 0) || !tRead) && (tByte != nackAt);
      end else if (tRead && tByte >= 1 && !tDone) begin
        pat = rdPat(tByte);
        tgtSdaLow = !pat[7 - tBit];
      end else begin
        tgtSdaLow = 0;
      end
    end
    if (sclNow) highLen++; else lowLen++;
    prevScl = sclNow;
    prevSda = sdaNow;
  end

  // ---------------- checking ----------------
  int checks = 0, fails = 0;
  logic finished = 0;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input int a, input logic [7:0] d);
    @(negedge clk);
    regAddr = AW'(a); regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input int a, output logic [7:0] d);
    @(negedge clk);
    regAddr = AW'(a);
    #1 d = regRdata;
  endtask

  task automatic waitIdle(output logic [7:0] st);
    st = 8'h80;
    for (int k = 0; k < 20000 && st[7:6] == 2'b10; k++) regRead(1, st);
  endtask

  initial begin
    logic [7:0] rd, st;
    int s0, p0, n, nk, expBytes, bad;
    logic isRd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state
    regRead(1, rd);  check(rd == 8'h00, "R1 status after reset", rd, 0);
    regRead(0, rd);  check(rd == 8'h00, "R1 control reads zero", rd, 0);
    bad = 0;
    for (int i = 0; i < DEPTH; i++) begin regRead(2 + i, rd); if (rd != 0) bad++; end
    check(bad == 0, "R1 buffer zero after reset", bad, 0);
    regRead(DEPTH + 2, rd); check(rd == 8'h00, "R1 offset beyond buffer", rd, 0);
    check(!sclDriveLow && !sdaDriveLow, "R11 bus released after reset",
          {sclDriveLow, sdaDriveLow}, 0);

    // invalid counts
    s0 = starts;
    regWrite(0, 8'h80);
    repeat (40) @(negedge clk);
    regRead(1, rd); check(rd == 8'h00 && starts == s0, "R3 count zero ignored", rd, 0);
    regWrite(0, 8'h80 | 8'(DEPTH + 1));
    repeat (40) @(negedge clk);
    regRead(1, rd); check(rd == 8'h00 && starts == s0, "R3 count above depth ignored", rd, 0);

    // table of transfers
    for (int v = 0; v < 7; v++) begin
      n    = int'(VEC[v][31:24]);
      nk   = (VEC[v][15:8] == 8'hFF) ? -1 : int'(VEC[v][15:8]);
      isRd = VEC[v][16];
      regWrite(2, VEC[v][23:16]);
      for (int i = 1; i < n; i++) regWrite(2 + i, payload(v, i));
      nackAt = nk;
      s0 = starts; p0 = stops;
      regWrite(0, 8'h00);
      regWrite(0, 8'h80 | 8'(n));
      regRead(1, rd); check(rd == 8'h80, "R2 busy after start", rd, 8'h80);
      waitIdle(st);
      check(st[7:6] == VEC[v][1:0], isRd ? "R5/R6 final status" : "R4/R6 final status",
            st, {VEC[v][1:0], 6'b0});
      check(starts - s0 == 1 && stops - p0 == 1, "R7 one START and one STOP",
            (starts - s0) * 16 + (stops - p0), 17);
      check(!sclDriveLow && !sdaDriveLow, "R11 bus released after transfer",
            {sclDriveLow, sdaDriveLow}, 0);
      expBytes = (nk >= 0) ? nk + 1 : n;
      check(tByte == expBytes, "R6 bytes on bus", tByte, expBytes);
      check(rxBytes[0] == VEC[v][23:16], "R4 address byte", rxBytes[0], VEC[v][23:16]);
      if (!isRd) begin
        bad = 0;
        for (int i = 1; i < expBytes; i++) if (rxBytes[i] != payload(v, i)) bad++;
        check(bad == 0, "R4 written bytes MSB first", bad, 0);
      end else if (nk < 0) begin
        bad = 0;
        for (int i = 1; i < n; i++) begin regRead(2 + i, rd); if (rd != rdPat(i)) bad++; end
        check(bad == 0, "R5 received bytes stored", bad, 0);
        bad = 0;
        for (int i = 1; i < n; i++) if (ackSeen[i] != (i != n - 1)) bad++;
        check(bad == 0, "R5 master ACK all but last", bad, 0);
      end
    end

    // clear status
    regWrite(0, 8'h00);
    regRead(1, rd); check(rd == 8'h00, "R10 zero write clears status", rd, 0);

    // writes during a transfer
    nackAt = -1;
    regWrite(2, 8'hA0); regWrite(3, 8'h11); regWrite(5, 8'h77);
    s0 = starts;
    regWrite(0, 8'h82);
    regWrite(3, 8'hEE); regWrite(5, 8'h99); regWrite(0, 8'h85); regWrite(0, 8'h00);
    regRead(1, rd); check(rd == 8'h80, "R9 control write ignored while busy", rd, 8'h80);
    waitIdle(st);
    check(st == 8'h40, "R9 transfer completes", st, 8'h40);
    check(rxBytes[1] == 8'h11, "R9 buffer write ignored on bus", rxBytes[1], 8'h11);
    regRead(5, rd); check(rd == 8'h77, "R9 buffer write ignored", rd, 8'h77);
    check(starts - s0 == 1, "R9 no restart", starts - s0, 1);

    check(timingSeen > 0 && timingBad == 0, "R8 SCL phase lengths", timingBad, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog R2 actual=busy expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks + 1);
      $finish;
    end
  end

endmodule